// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 62 level-sensitive interrupt inputs and drives a single interrupt request line toward a processor. Every channel has its own enable bit and a two-bit priority. Among channels that are both asserted and enabled, the lowest priority value wins. A tie goes to the lowest channel number. Software sees the block through a 32-bit register bus. Per-channel bit vectors are split into a low word (channels 0 to 31) and a high word (channels 32 to 61).

An interrupt is served in three steps. The handler first reads the vector register. That read returns the winning channel number shifted left by two, copies the number into a source-number register, and lowers the request line. The handler may then read the source-number register, which reports the plain channel number once and reads 0 afterwards. Finally the handler writes any value to the end-of-service register. After that write the block arbitrates again and raises the line if another enabled source is still pending.

Channel 0 is reserved, because a source number of 0 means that nothing is being served.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_out is low, all enables and priorities are 0, and the source-number register reads 0.
- R2: Writing 1s to 0x130 (low) or 0x134 (high) enables the matching channels. Writing 1s to 0x138 or 0x13C disables them. Zero bits change nothing. The enables read back at 0x128 (channels 0-31) and 0x12C (channel 32+b in bit b).
- R3: 0x100/0x104 show the input levels, sampled one clock late. 0x108/0x10C show those levels ANDed with the enables.
- R4: Priority words sit at 0x00 + 4k for k = 0..15. Channel 4k+j takes its priority from bits 8j+1:8j, and the other bits are not stored. The words read back as written.
- R5: The winner is the active channel with the smallest priority value. On a tie, the lowest channel number wins.
- R6: Reading 0x118 returns the winner number in bits 7:2, or 0 when no channel is active.
- R7: A read of 0x118 loads the winner (or 0) into bits 5:0 of 0x120. If a winner exists, the read also starts service and lowers irq_out on the same clock.
- R8: 0x120 reads as 0 after it has been read once.
- R9: irq_out rises one clock after an active channel exists and no service is open. It stays low while service is open, and falls when no channel is active.
- R10: A write of any data to 0x150 closes service. irq_out returns high on that clock if a channel is still active.
- R11: Channel 0 never becomes active and never wins.
- R12: Reads from unmapped or misaligned offsets return 0. Writes to read-only registers have no effect.
- R13: 0x110/0x114 hold a one-hot bit for the channel in service, and read 0 when no service is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_CH | Level interrupt inputs |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read and held until the next read |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A wrong enable or priority value shows up at the next vector read as a different channel number, or as irq_out taking the wrong level two clocks after an input change. A stuck service flag holds irq_out low after an end-of-service write even though a source is still active. This is visible on the first clock after that write. A source-number register that fails to clear returns a nonzero value on the second consecutive read, one cycle after that read is issued.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_W  = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;

  localparam logic [11:0] A_RAW_LO  = 12'h100;
  localparam logic [11:0] A_RAW_HI  = 12'h104;
  localparam logic [11:0] A_ACT_LO  = 12'h108;
  localparam logic [11:0] A_ACT_HI  = 12'h10C;
  localparam logic [11:0] A_ISR_LO  = 12'h110;
  localparam logic [11:0] A_ISR_HI  = 12'h114;
  localparam logic [11:0] A_VEC     = 12'h118;
  localparam logic [11:0] A_SRC     = 12'h120;
  localparam logic [11:0] A_MSK_LO  = 12'h128;
  localparam logic [11:0] A_MSK_HI  = 12'h12C;
  localparam logic [11:0] A_MEN_LO  = 12'h130;
  localparam logic [11:0] A_MEN_HI  = 12'h134;
  localparam logic [11:0] A_MDIS_LO = 12'h138;
  localparam logic [11:0] A_MDIS_HI = 12'h13C;
  localparam logic [11:0] A_EOS     = 12'h150;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_PRIO,
    SEL_RAW_LO, SEL_RAW_HI, SEL_ACT_LO, SEL_ACT_HI,
    SEL_ISR_LO, SEL_ISR_HI, SEL_VEC, SEL_SRC,
    SEL_MSK_LO, SEL_MSK_HI, SEL_MEN_LO, SEL_MEN_HI,
    SEL_MDIS_LO, SEL_MDIS_HI, SEL_EOS
  } reg_sel_e;
endpackage

// File: rtl/vic_mask_bank.sv
module vic_mask_bank #(
  parameter int NUM_CH = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic              clr_lo,
  input  logic              clr_hi,
  input  logic [31:0]       wdata,
  output logic [NUM_CH-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (((c < 32) ? clr_lo : clr_hi) && wdata[c % 32])
          mask_q[c] <= 1'b0;
        else if (((c < 32) ? set_lo : set_hi) && wdata[c % 32])
          mask_q[c] <= 1'b1;
      end
    end
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_lo |=> ((mask_q[31:0] & $past(wdata)) == $past(wdata)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_lo |=> ((mask_q[31:0] & $past(wdata)) == 32'd0));

endmodule

// File: rtl/vic_prio_regs.sv
module vic_prio_regs import vic_pkg::*; #(
  parameter int NUM_CH = 62,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [LANES*PRIO_W-1:0]  wd,
  output logic [BUS_W-1:0]         rd_word,
  output logic [NUM_CH*PRIO_W-1:0] prio_flat
);

  logic [PRIO_W-1:0] prio_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) prio_q[c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++)
        if (idx == IDX_W'(c / LANES))
          prio_q[c] <= wd[(c % LANES)*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (idx == IDX_W'(c / LANES))
        rd_word[(c % LANES)*LANE_W +: PRIO_W] = prio_q[c];
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      prio_flat[c*PRIO_W +: PRIO_W] = prio_q[c];
  end

  // R4
  prio_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == '0) |=> (prio_q[0] == $past(wd[PRIO_W-1:0])));

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_CH = 62,
  parameter int PRIO_W = 2,
  parameter int CH_W   = 6
) (
  input  logic [NUM_CH-1:0]        act,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  output logic                     win_valid,
  output logic [CH_W-1:0]          win_idx
);

  logic [PRIO_W-1:0] best;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (act[c] && (!win_valid || prio_flat[c*PRIO_W +: PRIO_W] < best)) begin
        win_valid = 1'b1;
        win_idx   = CH_W'(c);
        best      = prio_flat[c*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl import vic_pkg::*; #(
  parameter int NUM_CH = 62,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_src,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_out
);

  localparam int CH_W      = $clog2(NUM_CH);
  localparam int PRIO_REGS = (NUM_CH + LANES - 1) / LANES;
  localparam int PIDX_W    = $clog2(PRIO_REGS);

  reg_sel_e sel;
  logic rd, wr, vec_rd, src_rd, eos_wr;
  logic [NUM_CH-1:0] raw_q, mask_q, act;
  logic [63:0] raw_pad, act_pad, mask_pad, isr_pad;
  logic in_svc_q, in_svc_d, irq_q;
  logic [CH_W-1:0] svc_ch_q, srcnum_q, win_idx;
  logic win_valid;
  logic [BUS_W-1:0] rdata_q, rd_mux, prio_word, vec_word, src_word;
  logic [LANES*PRIO_W-1:0] prio_wd;
  logic [NUM_CH*PRIO_W-1:0] prio_flat;
  logic [PIDX_W-1:0] pidx;

  // address decode; misaligned offsets are unmapped
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr)
        ADDR_W'(A_RAW_LO):  sel = SEL_RAW_LO;
        ADDR_W'(A_RAW_HI):  sel = SEL_RAW_HI;
        ADDR_W'(A_ACT_LO):  sel = SEL_ACT_LO;
        ADDR_W'(A_ACT_HI):  sel = SEL_ACT_HI;
        ADDR_W'(A_ISR_LO):  sel = SEL_ISR_LO;
        ADDR_W'(A_ISR_HI):  sel = SEL_ISR_HI;
        ADDR_W'(A_VEC):     sel = SEL_VEC;
        ADDR_W'(A_SRC):     sel = SEL_SRC;
        ADDR_W'(A_MSK_LO):  sel = SEL_MSK_LO;
        ADDR_W'(A_MSK_HI):  sel = SEL_MSK_HI;
        ADDR_W'(A_MEN_LO):  sel = SEL_MEN_LO;
        ADDR_W'(A_MEN_HI):  sel = SEL_MEN_HI;
        ADDR_W'(A_MDIS_LO): sel = SEL_MDIS_LO;
        ADDR_W'(A_MDIS_HI): sel = SEL_MDIS_HI;
        ADDR_W'(A_EOS):     sel = SEL_EOS;
        default: if (bus_addr < ADDR_W'(PRIO_REGS*4)) sel = SEL_PRIO;
      endcase
    end
  end

  assign rd     = bus_req && !bus_we;
  assign wr     = bus_req && bus_we;
  assign vec_rd = rd && (sel == SEL_VEC);
  assign src_rd = rd && (sel == SEL_SRC);
  assign eos_wr = wr && (sel == SEL_EOS);
  assign pidx   = bus_addr[2 +: PIDX_W];

  always_comb begin
    for (int j = 0; j < LANES; j++)
      prio_wd[j*PRIO_W +: PRIO_W] = bus_wdata[j*LANE_W +: PRIO_W];
  end

  vic_mask_bank #(.NUM_CH(NUM_CH)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_lo (wr && sel == SEL_MEN_LO),
    .set_hi (wr && sel == SEL_MEN_HI),
    .clr_lo (wr && sel == SEL_MDIS_LO),
    .clr_hi (wr && sel == SEL_MDIS_HI),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  vic_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(PIDX_W)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr && sel == SEL_PRIO),
    .idx       (pidx),
    .wd        (prio_wd),
    .rd_word   (prio_word),
    .prio_flat (prio_flat)
  );

  always_comb begin
    act    = raw_q & mask_q;
    act[0] = 1'b0;
  end

  vic_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_arb (
    .act       (act),
    .prio_flat (prio_flat),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  // service state
  always_comb begin
    in_svc_d = in_svc_q;
    if (vec_rd && win_valid) in_svc_d = 1'b1;
    else if (eos_wr)         in_svc_d = 1'b0;
  end

  // 64-bit views for the two-word readback
  always_comb begin
    raw_pad  = '0;  raw_pad[NUM_CH-1:0]  = raw_q;
    act_pad  = '0;  act_pad[NUM_CH-1:0]  = act;
    mask_pad = '0;  mask_pad[NUM_CH-1:0] = mask_q;
    isr_pad  = '0;
    if (in_svc_q) isr_pad[svc_ch_q] = 1'b1;
    vec_word = '0;
    vec_word[2 +: CH_W] = win_valid ? win_idx : '0;
    src_word = '0;
    src_word[CH_W-1:0] = srcnum_q;
  end

  always_comb begin
    case (sel)
      SEL_PRIO:   rd_mux = prio_word;
      SEL_RAW_LO: rd_mux = raw_pad[31:0];
      SEL_RAW_HI: rd_mux = raw_pad[63:32];
      SEL_ACT_LO: rd_mux = act_pad[31:0];
      SEL_ACT_HI: rd_mux = act_pad[63:32];
      SEL_ISR_LO: rd_mux = isr_pad[31:0];
      SEL_ISR_HI: rd_mux = isr_pad[63:32];
      SEL_VEC:    rd_mux = vec_word;
      SEL_SRC:    rd_mux = src_word;
      SEL_MSK_LO: rd_mux = mask_pad[31:0];
      SEL_MSK_HI: rd_mux = mask_pad[63:32];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      in_svc_q <= 1'b0;
      svc_ch_q <= '0;
      srcnum_q <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      raw_q    <= irq_src;
      in_svc_q <= in_svc_d;
      irq_q    <= win_valid && !in_svc_d;
      if (vec_rd && win_valid) svc_ch_q <= win_idx;
      if (vec_rd)      srcnum_q <= win_valid ? win_idx : '0;
      else if (src_rd) srcnum_q <= '0;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  // R9
  irq_quiet_svc_chk: assert property (@(posedge clk) disable iff (rst)
    in_svc_q |-> !irq_out);

  // R9
  irq_has_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(win_valid));

  // R10
  eos_close_chk: assert property (@(posedge clk) disable iff (rst)
    eos_wr |=> !in_svc_q);

  // R8
  src_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> (srcnum_q == '0));

  // R7
  vec_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && win_valid) |=> (srcnum_q == $past(win_idx)) && in_svc_q && !irq_out);

  // R11
  ch0_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_idx != '0));

  // R5
  win_active_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> act[win_idx]);

  // R5
  no_win_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (act == '0));

endmodule

// File: tb/sim_vic_ctrl.sv
`timescale 1ns/1ps
module sim_vic_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [61:0] src = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic done = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  vic_ctrl u0 (
    .clk(clk), .rst(rst), .irq_src(src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always @(posedge clk) rd_seen <= !rst && bus_req && !bus_we;

  // monitor: compare each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen) begin
      tests++;
      if (q_exp.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expectation, got %h exp none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h exp %h", t, bus_rdata, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic pin(input logic e, input string t);
    tests++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out got %b exp %b", t, irq_out, e);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pin(1'b0, "R1 irq after reset");
    rd(12'h128, 32'h0, "R1 mask lo reset");
    rd(12'h120, 32'h0, "R1 srcnum reset");
    rd(12'h000, 32'h0, "R1 prio reset");

    rd(12'h200, 32'h0, "R12 unmapped read");
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0, "R12 raw write ignored");

    wr(12'h130, 32'h0000_00F1);
    rd(12'h128, 32'h0000_00F1, "R2 set lo");
    wr(12'h134, 32'h2000_0001);
    rd(12'h12C, 32'h2000_0001, "R2 set hi");
    wr(12'h138, 32'h0000_0030);
    rd(12'h128, 32'h0000_00C1, "R2 clear lo");
    wr(12'h130, 32'h0);
    rd(12'h128, 32'h0000_00C1, "R2 zero write no change");

    @(negedge clk);
    src = (62'd1 << 0) | (62'd1 << 3) | (62'd1 << 7) | (62'd1 << 61);
    settle();
    rd(12'h100, 32'h0000_0089, "R3 raw lo");
    rd(12'h104, 32'h2000_0000, "R3 raw hi");
    rd(12'h108, 32'h0000_0080, "R11 active lo excludes ch0");
    rd(12'h10C, 32'h2000_0000, "R3 active hi");
    rd(12'h102, 32'h0, "R12 misaligned read");
    pin(1'b1, "R9 irq raised");

    rd(12'h118, 32'h0000_001C, "R6 vector ch7");
    pin(1'b0, "R7 irq dropped on vector read");
    rd(12'h110, 32'h0000_0080, "R13 in-service lo");
    rd(12'h120, 32'h0000_0007, "R7 srcnum capture");
    rd(12'h120, 32'h0, "R8 srcnum cleared");
    settle();
    pin(1'b0, "R9 irq low in service");
    wr(12'h150, 32'h0);
    pin(1'b1, "R10 irq after end of service");
    rd(12'h110, 32'h0, "R13 in-service cleared");

    wr(12'h004, 32'hFE00_0000);
    rd(12'h004, 32'h0200_0000, "R4 prio field readback");
    wr(12'h03C, 32'h0);
    rd(12'h118, 32'h0000_00F4, "R5 priority winner ch61");
    rd(12'h120, 32'h0000_003D, "R7 srcnum ch61");
    wr(12'h150, 32'h1234_5678);

    wr(12'h03C, 32'h0000_0200);
    rd(12'h03C, 32'h0000_0200, "R4 prio ch61 lane1");
    rd(12'h118, 32'h0000_001C, "R5 tie lowest number");
    wr(12'h150, 32'h0);

    @(negedge clk);
    src = src | (62'd1 << 32);
    settle();
    rd(12'h10C, 32'h2000_0001, "R3 active hi two");
    rd(12'h118, 32'h0000_0080, "R5 ch32 beats lower priority");
    rd(12'h120, 32'h0000_0020, "R7 srcnum ch32");
    rd(12'h114, 32'h0000_0001, "R13 in-service hi");
    rd(12'h110, 32'h0, "R13 in-service lo empty");
    wr(12'h150, 32'h0);
    pin(1'b1, "R10 reassert");

    wr(12'h138, 32'hFFFF_FFFF);
    wr(12'h13C, 32'hFFFF_FFFF);
    rd(12'h128, 32'h0, "R2 all disabled lo");
    rd(12'h12C, 32'h0, "R2 all disabled hi");
    settle();
    pin(1'b0, "R2 irq low when disabled");
    rd(12'h118, 32'h0, "R6 vector none");
    rd(12'h120, 32'h0, "R7 srcnum none");
    settle();
    pin(1'b0, "R9 irq stays low");

    @(negedge clk);
    src = 62'd1 << 7;
    wr(12'h130, 32'h0000_0080);
    settle();
    pin(1'b1, "R9 irq on single source");
    @(negedge clk);
    src = '0;
    settle();
    pin(1'b0, "R9 irq falls with level");

    @(negedge clk);
    while (q_exp.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule